// File: doc/BRIEF.md
# Fused Compare-and-Branch Resolver

This block resolves one family of 32-bit branch instructions, all carrying primary opcode 1. Each one either compares a register with a second register or a small immediate, or isolates a single bit of a register, then writes a fresh 4-bit condition field and decides whether to branch. The branch is taken when one chosen bit of that new condition field matches a polarity bit in the instruction word. Some variants also write a modified value back into the compared register, and any variant can request a link-register update.

The execute stage presents the instruction word, its address, the two operand register values and the current summary-overflow flag together with a valid strobe. One clock later the block returns the decision, the branch destination, the fall-through address, the new condition field, the link write and the optional register writeback. It also flags encodings that name a register the core does not implement. Fetch redirection and hazard handling are left to the surrounding pipeline.

Top module: `fcb_unit`

## Requirements
- R1: Instruction bits are numbered 31 (MSB) down to 0: opcode [31:26] = 000001, form [25:24], polarity [23], selector [22:21], ra index [20:16], rb field [15:11], displacement [10:1] (signed), link [0]. The destination is the instruction address plus the sign-extended displacement times 4, and the fall-through address is the instruction address plus 4.
- R2: Form 00 compares ra with rb as signed 32-bit numbers and writes the condition field as {LT, GT, EQ, SO} in bits [3:0], with exactly one of LT, GT, EQ set.
- R3: Form 01 compares ra with rb as unsigned numbers.
- R4: Form 10 compares ra (signed) with the 5-bit rb field zero-extended to 32 bits.
- R5: In forms 00, 01 and 10 with selector 0, 1 or 2, the branch is taken when LT, GT or EQ respectively equals the polarity bit.
- R6: In forms 00, 01 and 10 with selector 3, ra is written back with ra minus the operand, the compare uses the old ra, and the branch tests EQ; no other selector writes ra in these forms.
- R7: Form 11 with selector 00 or 01 tests one bit: the mask is 0x80000000 shifted right by n, where n is the rb field (00) or rb[4:0] (01); ra AND mask is compared unsigned with zero (LT=0, GT=result nonzero, EQ=result zero), the branch is taken when EQ equals the polarity bit, and ra is not written.
- R8: Form 11 with selector 10 (n from the rb field) or 11 (n from rb[4:0]) computes ra AND NOT mask, writes it back to ra, sets the condition field from it as in R7 and branches when EQ equals the polarity bit.
- R9: With the link bit set, the link write is enabled and carries the fall-through address whether or not the branch is taken.
- R10: The instruction is illegal when the opcode differs from 000001, when the ra index is outside the allowed set (bitmap 0xF00027FF, bit k allowing register k), or when a register-valued rb (forms 00, 01, and form 11 selectors 01 and 11) is outside that set; an illegal instruction takes no branch and enables neither the link write nor the ra write.
- R11: Results appear one clock after valid_i with done_o high; in a cycle after valid_i was low, done_o and all write and branch strobes are low; synchronous reset clears every strobe.
- R12: Bit 0 of the condition field always equals the summary-overflow input of the same instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Instruction present this cycle |
| insn_i | input | 32 | Instruction word |
| pc_i | input | AW | Address of the instruction |
| ra_val_i | input | DW | Value of register ra |
| rb_val_i | input | DW | Value of register rb |
| so_i | input | 1 | Current summary-overflow flag |
| done_o | output | 1 | Result valid (one cycle after valid_i) |
| taken_o | output | 1 | Branch taken |
| target_o | output | AW | Branch destination |
| next_pc_o | output | AW | Fall-through address |
| cr0_o | output | 4 | New condition field {LT, GT, EQ, SO} |
| lr_we_o | output | 1 | Link register write enable |
| lr_val_o | output | AW | Link register value |
| ra_we_o | output | 1 | ra writeback enable |
| ra_val_o | output | DW | ra writeback value |
| illegal_o | output | 1 | Illegal encoding |

## Verification
The bench builds the block at its default widths, 32-bit addresses and data with the stock register bitmap, which is also the only width the instruction format supports. At that size every form, selector, polarity and link combination can be crossed with all 32 bit positions and several operand patterns chosen to hit equal, signed-versus-unsigned disagreement and sign-extended displacement cases. All 1024 ra/rb index pairs are swept against the allowed-register bitmap, together with a foreign opcode.

// File: rtl/fcb_pkg.sv
package fcb_pkg;

  localparam int INSN_W = 32;
  localparam int DISP_W = 10;
  localparam logic [5:0] FCB_OPCODE = 6'b000001;

  typedef enum logic [1:0] {
    SUB_CMP_S = 2'b00,
    SUB_CMP_U = 2'b01,
    SUB_CMP_I = 2'b10,
    SUB_BIT   = 2'b11
  } sub_e;

  // Laid out MSB first so the word maps straight onto the struct
  typedef struct packed {
    logic [5:0]        opc;
    sub_e              sub;
    logic              px;
    logic [1:0]        bix;
    logic [4:0]        ra_idx;
    logic [4:0]        rb_idx;
    logic [DISP_W-1:0] bd;
    logic              lk;
  } fields_t;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cr_t;

endpackage

// File: rtl/fcb_decode.sv
module fcb_decode
  import fcb_pkg::*;
#(
  parameter logic [31:0] REG_MAP = 32'hF000_27FF
) (
  input  logic [INSN_W-1:0] insn_i,
  output fields_t           fields_o,
  output logic              illegal_o
);

  logic rb_is_reg;

  always_comb begin
    fields_o  = insn_i;
    rb_is_reg = (fields_o.sub == SUB_CMP_S) || (fields_o.sub == SUB_CMP_U) ||
                ((fields_o.sub == SUB_BIT) && fields_o.bix[0]);
    illegal_o = (fields_o.opc != FCB_OPCODE) ||
                !REG_MAP[fields_o.ra_idx] ||
                (rb_is_reg && !REG_MAP[fields_o.rb_idx]);
  end

endmodule

// File: rtl/fcb_cmp.sv
module fcb_cmp
  import fcb_pkg::*;
#(
  parameter int DW = 32
) (
  input  sub_e          sub_i,
  input  logic [1:0]    bix_i,
  input  logic [4:0]    imm_i,
  input  logic [DW-1:0] ra_i,
  input  logic [DW-1:0] rb_i,
  output logic [2:0]    flags_o,
  output logic          wb_o,
  output logic [DW-1:0] res_o,
  output logic [1:0]    sel_o
);

  logic [DW-1:0] opnd;
  logic          signed_cmp;
  logic          lt, gt, eq;

  always_comb begin
    opnd       = (sub_i == SUB_CMP_I) ? DW'(imm_i) : rb_i;
    signed_cmp = (sub_i != SUB_CMP_U);
    eq         = (ra_i == opnd);
    if (signed_cmp) begin
      lt = $signed(ra_i) < $signed(opnd);
      gt = $signed(ra_i) > $signed(opnd);
    end else begin
      lt = ra_i < opnd;
      gt = ra_i > opnd;
    end
    flags_o = {lt, gt, eq};
    wb_o    = (bix_i == 2'd3);
    res_o   = ra_i - opnd;
    sel_o   = wb_o ? 2'd2 : bix_i;
  end

endmodule

// File: rtl/fcb_bitop.sv
module fcb_bitop #(
  parameter int DW = 32,
  localparam int SH_W = $clog2(DW)
) (
  input  logic [1:0]      bix_i,
  input  logic [4:0]      imm_i,
  input  logic [SH_W-1:0] rbn_i,
  input  logic [DW-1:0]   ra_i,
  output logic [2:0]      flags_o,
  output logic            wb_o,
  output logic [DW-1:0]   res_o
);

  logic [SH_W-1:0] bitn;
  logic [DW-1:0]   mask;

  assign bitn = bix_i[0] ? rbn_i : SH_W'(imm_i);

  // Bit number n counts from the MSB: position DW-1-n carries the mask
  for (genvar i = 0; i < DW; i++) begin : g_mask
    assign mask[i] = (bitn == SH_W'(DW - 1 - i));
  end

  always_comb begin
    res_o   = bix_i[1] ? (ra_i & ~mask) : (ra_i & mask);
    wb_o    = bix_i[1];
    flags_o = {1'b0, (res_o != '0), (res_o == '0)};
  end

endmodule

// File: rtl/fcb_unit.sv
module fcb_unit
  import fcb_pkg::*;
#(
  parameter int          AW      = 32,
  parameter int          DW      = 32,
  parameter logic [31:0] REG_MAP = 32'hF000_27FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [INSN_W-1:0] insn_i,
  input  logic [AW-1:0]     pc_i,
  input  logic [DW-1:0]     ra_val_i,
  input  logic [DW-1:0]     rb_val_i,
  input  logic              so_i,
  output logic              done_o,
  output logic              taken_o,
  output logic [AW-1:0]     target_o,
  output logic [AW-1:0]     next_pc_o,
  output logic [3:0]        cr0_o,
  output logic              lr_we_o,
  output logic [AW-1:0]     lr_val_o,
  output logic              ra_we_o,
  output logic [DW-1:0]     ra_val_o,
  output logic              illegal_o
);

  localparam int SH_W   = $clog2(DW);
  localparam int EXT_W  = AW - DISP_W - 2;

  fields_t       f;
  logic          bad;
  logic [2:0]    cmp_flags, bit_flags;
  logic          cmp_wb, bit_wb;
  logic [DW-1:0] cmp_res, bit_res;
  logic [1:0]    cmp_sel;

  fcb_decode #(.REG_MAP(REG_MAP)) u_dec (
    .insn_i    (insn_i),
    .fields_o  (f),
    .illegal_o (bad)
  );

  fcb_cmp #(.DW(DW)) u_cmp (
    .sub_i   (f.sub),
    .bix_i   (f.bix),
    .imm_i   (f.rb_idx),
    .ra_i    (ra_val_i),
    .rb_i    (rb_val_i),
    .flags_o (cmp_flags),
    .wb_o    (cmp_wb),
    .res_o   (cmp_res),
    .sel_o   (cmp_sel)
  );

  fcb_bitop #(.DW(DW)) u_bit (
    .bix_i   (f.bix),
    .imm_i   (f.rb_idx),
    .rbn_i   (rb_val_i[SH_W-1:0]),
    .ra_i    (ra_val_i),
    .flags_o (bit_flags),
    .wb_o    (bit_wb),
    .res_o   (bit_res)
  );

  logic          is_bit;
  cr_t           cr_d;
  logic [1:0]    sel, pick;
  logic          taken_d, wb_d;
  logic [DW-1:0] res_d;
  logic [AW-1:0] target_d, next_d;

  always_comb begin
    is_bit   = (f.sub == SUB_BIT);
    cr_d     = {(is_bit ? bit_flags : cmp_flags), so_i};
    sel      = is_bit ? 2'd2 : cmp_sel;
    pick     = 2'd3 - sel;
    taken_d  = !bad && (cr_d[pick] == f.px);
    wb_d     = !bad && (is_bit ? bit_wb : cmp_wb);
    res_d    = is_bit ? bit_res : cmp_res;
    next_d   = pc_i + AW'(4);
    target_d = pc_i + {{EXT_W{f.bd[DISP_W-1]}}, f.bd, 2'b00};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o    <= 1'b0;
      taken_o   <= 1'b0;
      lr_we_o   <= 1'b0;
      ra_we_o   <= 1'b0;
      illegal_o <= 1'b0;
      target_o  <= '0;
      next_pc_o <= '0;
      lr_val_o  <= '0;
      ra_val_o  <= '0;
      cr0_o     <= '0;
    end else begin
      done_o    <= valid_i;
      taken_o   <= valid_i && taken_d;
      lr_we_o   <= valid_i && !bad && f.lk;
      ra_we_o   <= valid_i && wb_d;
      illegal_o <= valid_i && bad;
      if (valid_i) begin
        target_o  <= target_d;
        next_pc_o <= next_d;
        lr_val_o  <= next_d;
        ra_val_o  <= res_d;
        cr0_o     <= cr_d;
      end
    end
  end

endmodule

// File: rtl/fcb_unit_chk.sv
module fcb_unit_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          valid_i,
  input logic [4:0]    ctl_i,
  input logic [AW-1:0] pc_i,
  input logic          so_i,
  input logic          done_o,
  input logic          taken_o,
  input logic [AW-1:0] next_pc_o,
  input logic [3:0]    cr0_o,
  input logic          lr_we_o,
  input logic [AW-1:0] lr_val_o,
  input logic          ra_we_o,
  input logic          illegal_o
);

  logic [1:0] q_sub, q_bix, q_sel, q_pick;
  logic       q_px;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_sub <= '0;
      q_px  <= 1'b0;
      q_bix <= '0;
    end else if (valid_i) begin
      q_sub <= ctl_i[4:3];
      q_px  <= ctl_i[2];
      q_bix <= ctl_i[1:0];
    end
  end

  always_comb begin
    q_sel  = ((q_sub == 2'b11) || (q_bix == 2'd3)) ? 2'd2 : q_bix;
    q_pick = 2'd3 - q_sel;
  end

  // R11
  done_follow_chk: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> done_o);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> (!done_o && !taken_o && !lr_we_o && !ra_we_o));

  // R10
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> (!taken_o && !lr_we_o && !ra_we_o));

  // R9
  link_value_chk: assert property (@(posedge clk) disable iff (rst)
    lr_we_o |-> (lr_val_o == next_pc_o));

  // R1
  next_addr_chk: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> (next_pc_o == $past(pc_i) + AW'(4)));

  // R12
  so_slot_chk: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> (cr0_o[0] == $past(so_i)));

  // R2
  one_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !illegal_o) |-> ($countones(cr0_o[3:1]) == 1));

  // R5
  taken_match_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !illegal_o) |-> (taken_o == (cr0_o[q_pick] == q_px)));

  // R6
  cmp_wb_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !illegal_o && (q_sub != 2'b11)) |-> (ra_we_o == (q_bix == 2'd3)));

  // R7
  test_nowb_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && (q_sub == 2'b11) && !q_bix[1]) |-> !ra_we_o);

endmodule

bind fcb_unit fcb_unit_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .valid_i   (valid_i),
  .ctl_i     (insn_i[25:21]),
  .pc_i      (pc_i),
  .so_i      (so_i),
  .done_o    (done_o),
  .taken_o   (taken_o),
  .next_pc_o (next_pc_o),
  .cr0_o     (cr0_o),
  .lr_we_o   (lr_we_o),
  .lr_val_o  (lr_val_o),
  .ra_we_o   (ra_we_o),
  .illegal_o (illegal_o)
);

// File: tb/tb_fcb_unit.sv
`timescale 1ns/1ps
module tb_fcb_unit;

  localparam logic [31:0] MAP = 32'hF000_27FF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_i = 1'b0;
  logic [31:0] insn_i = '0;
  logic [31:0] pc_i = '0;
  logic [31:0] ra_val_i = '0;
  logic [31:0] rb_val_i = '0;
  logic        so_i = 1'b0;
  logic        done_o, taken_o, lr_we_o, ra_we_o, illegal_o;
  logic [31:0] target_o, next_pc_o, lr_val_o, ra_val_o;
  logic [3:0]  cr0_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  fcb_unit dut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .insn_i(insn_i), .pc_i(pc_i),
    .ra_val_i(ra_val_i), .rb_val_i(rb_val_i), .so_i(so_i),
    .done_o(done_o), .taken_o(taken_o), .target_o(target_o),
    .next_pc_o(next_pc_o), .cr0_o(cr0_o), .lr_we_o(lr_we_o),
    .lr_val_o(lr_val_o), .ra_we_o(ra_we_o), .ra_val_o(ra_val_o),
    .illegal_o(illegal_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] opc, input logic [1:0] sub,
                                     input logic px, input logic [1:0] bix,
                                     input logic [4:0] ra, input logic [4:0] rb,
                                     input logic [9:0] bd, input logic lk);
    return {opc, sub, px, bix, ra, rb, bd, lk};
  endfunction

  // Drive one instruction, then compare against a model built from the requirements
  task automatic run(input logic [31:0] insn, input logic [31:0] pc,
                     input logic [31:0] ra, input logic [31:0] rb, input logic so);
    logic [1:0] sub, bix;
    logic px, lk, legal, rb_reg, lt, gt, eq, hit, wb_exp;
    logic [4:0] rai, rbi, n;
    logic [9:0] bd;
    logic [31:0] wb_val, r, tgt, opnd;
    longint av, ov;
    string ctag, ttag, wtag;

    sub = insn[25:24]; px = insn[23]; bix = insn[22:21];
    rai = insn[20:16]; rbi = insn[15:11]; bd = insn[10:1]; lk = insn[0];
    rb_reg = (sub == 2'd0) || (sub == 2'd1) || (sub == 2'd3 && bix[0]);
    legal = (insn[31:26] == 6'd1) && MAP[rai] && (!rb_reg || MAP[rbi]);
    wb_val = '0;
    if (sub != 2'd3) begin
      opnd = (sub == 2'd2) ? {27'd0, rbi} : rb;
      av = (sub == 2'd1) ? longint'(ra) : longint'($signed(ra));
      ov = (sub == 2'd0) ? longint'($signed(rb)) : longint'(opnd);
      lt = av < ov; gt = av > ov; eq = av == ov;
      wb_exp = (bix == 2'd3);
      wb_val = ra - opnd;
      case (bix)
        2'd0: hit = lt;
        2'd1: hit = gt;
        default: hit = eq;
      endcase
      ctag = (sub == 2'd0) ? "R2 signed cr0" : (sub == 2'd1) ? "R3 unsigned cr0" : "R4 imm cr0";
      ttag = (bix == 2'd3) ? "R6 taken" : "R5 taken";
      wtag = "R6 ra writeback";
    end else begin
      n = bix[0] ? rb[4:0] : rbi;
      r = ra;
      if (bix[1]) begin
        r[31 - n] = 1'b0;
      end else begin
        r = ra[31 - n] ? (32'h1 << (31 - n)) : 32'h0;
      end
      lt = 1'b0; gt = (r != 0); eq = (r == 0);
      hit = eq;
      wb_exp = bix[1];
      wb_val = r;
      ctag = bix[1] ? "R8 clear cr0" : "R7 test cr0";
      ttag = bix[1] ? "R8 taken" : "R7 taken";
      wtag = bix[1] ? "R8 ra writeback" : "R7 no ra write";
    end
    tgt = pc + 32'(longint'($signed({bd, 2'b00})));

    @(negedge clk);
    insn_i = insn; pc_i = pc; ra_val_i = ra; rb_val_i = rb; so_i = so; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    check("R11 done", {31'd0, done_o}, 32'd1);
    check("R10 illegal flag", {31'd0, illegal_o}, {31'd0, !legal});
    if (legal) begin
      check(ctag, {28'd0, cr0_o}, {28'd0, lt, gt, eq, so});
      check("R12 so slot", {31'd0, cr0_o[0]}, {31'd0, so});
      check(ttag, {31'd0, taken_o}, {31'd0, hit == px});
      check("R1 target", target_o, tgt);
      check("R1 next", next_pc_o, pc + 32'd4);
      check("R9 link enable", {31'd0, lr_we_o}, {31'd0, lk});
      if (lk) check("R9 link value", lr_val_o, pc + 32'd4);
      check(wtag, {31'd0, ra_we_o}, {31'd0, wb_exp});
      if (wb_exp) check(wtag, ra_val_o, wb_val);
    end else begin
      check("R10 no branch", {31'd0, taken_o}, 32'd0);
      check("R10 no link", {31'd0, lr_we_o}, 32'd0);
      check("R10 no ra write", {31'd0, ra_we_o}, 32'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] pc;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 reset done", {31'd0, done_o}, 32'd0);
    check("R11 reset taken", {31'd0, taken_o}, 32'd0);
    check("R11 reset strobes", {30'd0, lr_we_o, ra_we_o}, 32'd0);
    rst = 1'b0;
    pc = 32'h0000_4000;

    // Main sweep: every form, selector, polarity and link, 32 bit positions, 4 patterns
    for (int sub = 0; sub < 4; sub++)
      for (int bix = 0; bix < 4; bix++)
        for (int px = 0; px < 2; px++)
          for (int lk = 0; lk < 2; lk++)
            for (int k = 0; k < 32; k++)
              for (int p = 0; p < 4; p++) begin
                logic [31:0] ra, rb;
                logic [4:0]  rbi;
                logic        reg_rb;
                case (p)
                  0: ra = 32'(k);
                  1: ra = 32'(0 - k);
                  2: ra = 32'h8000_0000 | 32'(k);
                  default: ra = 32'h7FFF_FFF0 + 32'(k);
                endcase
                rb = k[0] ? ra : (32'(k) - 32'd8) ^ (p[0] ? 32'hFFFF_0000 : 32'h0);
                if (sub == 3) rb = {ra[31:5], 5'(k + p)};
                if (sub == 2 && k[0]) ra = 32'(k);
                reg_rb = (sub < 2) || (sub == 3 && bix[0]);
                rbi = reg_rb ? 5'd13 : 5'(k);
                pc = pc + 32'd4;
                run(mk(6'd1, 2'(sub), px[0], 2'(bix), 5'd3, rbi,
                       10'(k * 37 + p * 300), lk[0]),
                    pc, ra, rb, k[1]);
              end

    // R10: all register index pairs against the allowed bitmap
    for (int a = 0; a < 32; a++)
      for (int b = 0; b < 32; b++)
        run(mk(6'd1, 2'd0, 1'b1, 2'd3, 5'(a), 5'(b), 10'd5, 1'b1),
            32'h100, 32'd7, 32'd7, 1'b0);

    // R10: immediate rb field ignores the bitmap; foreign opcode is illegal
    run(mk(6'd1, 2'd2, 1'b1, 2'd2, 5'd3, 5'd20, 10'd1, 1'b1), 32'h200, 32'd20, 32'd0, 1'b1);
    run(mk(6'd2, 2'd0, 1'b1, 2'd2, 5'd3, 5'd4, 10'd1, 1'b1), 32'h200, 32'd1, 32'd1, 1'b0);

    // R11: an idle cycle leaves every strobe low
    @(negedge clk);
    check("R11 idle done", {31'd0, done_o}, 32'd0);
    check("R11 idle strobes", {29'd0, taken_o, lr_we_o, ra_we_o}, 32'd0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule